// File: doc/BRIEF.md
# Handshake-Stepped Pseudo-Random Self-Test Engine

This block drives a parallel self-test of N identical 8-bit magnitude comparator cells. A 16-bit maximal-length linear feedback shift register supplies the stimulus. It does not run freely on the clock. It moves forward by exactly one state for each four-phase request/acknowledge handshake on its stepping port. The low byte of the register is broadcast to every cell. Handshakes are grouped in pairs. The first handshake of a pair tells the cells to capture the byte as their stored operand. The second tells them to capture it as their incoming operand.

Each cell returns one compare bit. The engine folds the N bits into a single parity observation, which stays 0 on a fault-free array because all cells see identical operands. One cycle after the second operand of a pair has been captured, the engine samples that parity. Any 1 sets a sticky fail flag. A start pulse reseeds the register and begins a run. The run ends with a done flag once the programmed number of pairs has been applied.

Top module: `lfsr_bist_engine`

## Requirements
- R1: Out of reset: `ack_o`, `ld_first_o`, `ld_second_o`, `fail_o`, `done_o` and `busy_o` are 0, and `tdat_o` equals bits [7:0] of the seed (default 16'hACE1).
- R2: Each accepted handshake moves the 16-bit state s to {s[14:0], s[15]^s[4]^s[3]^s[2]} (polynomial 1 + x^3 + x^4 + x^5 + x^16, period 2^16 - 1, never all zero). `tdat_o` is bits [7:0] of the new state when `ack_o` is first seen high. It changes at no other time except on a start.
- R3: While a run is busy and no pair result is pending, `req_i` high with `ack_o` low raises `ack_o` on the next clock edge. `ack_o` returns low on the first edge at which `req_i` is low.
- R4: Within a pair, the first accepted handshake raises `ld_first_o` and the second raises `ld_second_o`. Each is a one-cycle pulse aligned with the rise of `ack_o`, and the two are never high together.
- R5: `mix_o` is the combinational XOR of all N bits of `cmp_res_i`.
- R6: `mix_o` is sampled two edges after the edge that raised `ld_second_o`. A 1 there sets `fail_o`, which then stays set until the next start.
- R7: After NUM_PAIRS pair samples, `done_o` rises and `busy_o` falls. Afterwards requests are not acknowledged and `tdat_o` holds.
- R8: A `start_i` pulse reseeds the state, clears `fail_o`, `done_o` and the pair count, sets `busy_o`, and makes the next handshake the first of a pair.
- R9: Before any start, requests are not acknowledged and `tdat_o` holds.
- R10: A value of 1 on `mix_o` outside a pair sample cycle does not set `fail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a new run |
| req_i | input | 1 | Four-phase step request |
| ack_o | output | 1 | Four-phase step acknowledge |
| tdat_o | output | TDAT_W | Test byte broadcast to all cells |
| ld_first_o | output | 1 | Cells capture `tdat_o` as stored operand |
| ld_second_o | output | 1 | Cells capture `tdat_o` as incoming operand |
| cmp_res_i | input | N_CELLS | Compare result of each cell |
| mix_o | output | 1 | Parity of all compare results |
| fail_o | output | 1 | Sticky fail flag for the current run |
| done_o | output | 1 | All pairs of the run applied |
| busy_o | output | 1 | Run in progress |

## Verification
The bench builds the engine with four cells and a run of five pairs. This makes it possible to walk every handshake of several whole runs, including the done boundary and back-to-back runs, and to compare every byte against a model of the recurrence in the bench. The bench models the cells in behaviour, as captured operand pairs compared with less-than. It can invert one cell's result to inject a fault at chosen moments: inside a run, to set the sticky flag, and while idle, to show that the sampling window ignores it.

// File: rtl/bist_pkg.sv
// Shared types and defaults for the self-test engine.
// Assumes a shift-left Fibonacci register whose tap mask selects feedback bits.
package bist_pkg;
    // Taps at bits 15,4,3,2: polynomial 1 + x^3 + x^4 + x^5 + x^16
    localparam logic [15:0] DEF_TAPS = 16'h801C;
    localparam logic [15:0] DEF_SEED = 16'hACE1;

    typedef enum logic {
        SLOT_FIRST  = 1'b0,
        SLOT_SECOND = 1'b1
    } slot_e;
endpackage

// File: rtl/bist_lfsr.sv
// Handshake-stepped LFSR: advances only when step_i is high, reloads the seed on reseed_i.
// Assumes SEED is non-zero and TAPS describes a primitive polynomial.
module bist_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = bist_pkg::DEF_TAPS,
    parameter logic [W-1:0] SEED = bist_pkg::DEF_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reseed_i,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic fb;

    // Feedback is the parity of the tapped bits
    assign fb = ^(state_o & TAPS);

    // State register: seed on reset or reseed, shift on step
    always_ff @(posedge clk) begin
        if (!rst_n || reseed_i) begin
            state_o <= SEED;
        end else if (step_i) begin
            state_o <= {state_o[W-2:0], fb};
        end
    end
endmodule

// File: rtl/bist_xor_compact.sv
// Folds N compare bits into one parity bit through an explicit XOR chain.
// Assumes N >= 1; purely combinational.
module bist_xor_compact #(
    parameter int N = 64
) (
    input  logic [N-1:0] bits_i,
    output logic         parity_o
);
    logic [N:0] chain;

    assign chain[0] = 1'b0;

    // One XOR stage per cell result
    for (genvar i = 0; i < N; i++) begin : g_stage
        assign chain[i+1] = chain[i] ^ bits_i[i];
    end

    assign parity_o = chain[N];
endmodule

// File: rtl/bist_seq.sv
// Handshake and pair sequencer: accepts four-phase steps, marks first/second operand,
// samples the parity one cycle after the second operand is captured, counts pairs.
// Assumes start_i is a single-cycle pulse and NUM_PAIRS >= 1.
module bist_seq #(
    parameter int NUM_PAIRS = 1000,
    localparam int CNT_W    = $clog2(NUM_PAIRS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic req_i,
    input  logic mix_i,
    output logic ack_o,
    output logic step_o,
    output logic ld_first_o,
    output logic ld_second_o,
    output logic fail_o,
    output logic done_o,
    output logic busy_o
);
    import bist_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_PAIRS - 1);

    slot_e             slot;
    logic              pend;
    logic [CNT_W-1:0]  cnt;
    logic              accept;

    // A step is taken on a fresh request while running and no result is pending
    assign accept = busy_o && req_i && !ack_o && !pend && !start_i;
    assign step_o = accept;

    // Four-phase acknowledge: rise on accept, fall once request is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
        end else if (accept) begin
            ack_o <= 1'b1;
        end else if (!req_i) begin
            ack_o <= 1'b0;
        end
    end

    // Operand-slot tracking and one-cycle load strobes
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            slot        <= SLOT_FIRST;
            ld_first_o  <= 1'b0;
            ld_second_o <= 1'b0;
        end else begin
            ld_first_o  <= accept && (slot == SLOT_FIRST);
            ld_second_o <= accept && (slot == SLOT_SECOND);
            if (accept) begin
                slot <= (slot == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
            end
        end
    end

    // Pending flag marks the cycle in which the pair result is sampled
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            pend <= 1'b0;
        end else begin
            pend <= ld_second_o;
        end
    end

    // Run control: start, sticky fail, pair count and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            fail_o <= 1'b0;
            cnt    <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            done_o <= 1'b0;
            fail_o <= 1'b0;
            cnt    <= '0;
        end else if (pend) begin
            fail_o <= fail_o | mix_i;
            cnt    <= cnt + 1'b1;
            if (cnt == LAST) begin
                done_o <= 1'b1;
                busy_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lfsr_bist_engine.sv
// Top of the self-test engine: LFSR stimulus, pair sequencer and parity compactor.
// Assumes all cells are identical so a fault-free array yields even parity.
module lfsr_bist_engine #(
    parameter int                 N_CELLS   = 64,
    parameter int                 NUM_PAIRS = 1000,
    parameter int                 LFSR_W    = 16,
    parameter int                 TDAT_W    = 8,
    parameter logic [LFSR_W-1:0]  TAPS      = bist_pkg::DEF_TAPS,
    parameter logic [LFSR_W-1:0]  SEED      = bist_pkg::DEF_SEED
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               req_i,
    output logic               ack_o,
    output logic [TDAT_W-1:0]  tdat_o,
    output logic               ld_first_o,
    output logic               ld_second_o,
    input  logic [N_CELLS-1:0] cmp_res_i,
    output logic               mix_o,
    output logic               fail_o,
    output logic               done_o,
    output logic               busy_o
);
    logic [LFSR_W-1:0] lfsr_state;
    logic              step;

    bist_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .reseed_i (start_i),
        .step_i   (step),
        .state_o  (lfsr_state)
    );

    bist_xor_compact #(.N(N_CELLS)) u_mix (
        .bits_i   (cmp_res_i),
        .parity_o (mix_o)
    );

    bist_seq #(.NUM_PAIRS(NUM_PAIRS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .req_i       (req_i),
        .mix_i       (mix_o),
        .ack_o       (ack_o),
        .step_o      (step),
        .ld_first_o  (ld_first_o),
        .ld_second_o (ld_second_o),
        .fail_o      (fail_o),
        .done_o      (done_o),
        .busy_o      (busy_o)
    );

    // Broadcast the low byte of the register as test data
    assign tdat_o = lfsr_state[TDAT_W-1:0];
endmodule

// File: rtl/lfsr_bist_engine_chk.sv
// Temporal checks on the self-test engine, attached by bind.
module lfsr_bist_engine_chk #(
    parameter int LFSR_W = 16,
    parameter int TDAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              req_i,
    input logic              ack_o,
    input logic [TDAT_W-1:0] tdat_o,
    input logic              ld_first_o,
    input logic              ld_second_o,
    input logic              mix_o,
    input logic              fail_o,
    input logic              done_o,
    input logic [LFSR_W-1:0] lfsr_state
);
    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);

    // R2
    tdat_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdat_o) |-> ($rose(ack_o) || $past(start_i)));

    // R3
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_i));

    // R3
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !req_i) |=> !ack_o);

    // R4
    ld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_first_o, ld_second_o}));

    // R4
    ld_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_first_o || ld_second_o) |-> (ack_o && !$past(ack_o)));

    // R6
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o);

    // R6
    fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> $past(mix_o));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
endmodule

bind lfsr_bist_engine lfsr_bist_engine_chk #(.LFSR_W(LFSR_W), .TDAT_W(TDAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_i       (req_i),
    .ack_o       (ack_o),
    .tdat_o      (tdat_o),
    .ld_first_o  (ld_first_o),
    .ld_second_o (ld_second_o),
    .mix_o       (mix_o),
    .fail_o      (fail_o),
    .done_o      (done_o),
    .lfsr_state  (lfsr_state)
);

// File: tb/lfsr_bist_engine_tb.sv
module lfsr_bist_engine_tb;
    localparam int          NC    = 4;
    localparam int          NP    = 5;
    localparam logic [15:0] SEEDV = 16'hACE1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          req = 1'b0;
    logic          ack;
    logic [7:0]    tdat;
    logic          ld_a, ld_b;
    logic [NC-1:0] cmp;
    logic          mix, fail, done, busy;

    logic [7:0]    sa [NC];
    logic [7:0]    sb [NC];
    logic          inject = 1'b0;
    logic [15:0]   model;
    int            checks = 0;
    int            errors = 0;
    bit            finished = 1'b0;

    always #5 clk = ~clk;

    lfsr_bist_engine #(.N_CELLS(NC), .NUM_PAIRS(NP), .SEED(SEEDV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .req_i(req), .ack_o(ack),
        .tdat_o(tdat), .ld_first_o(ld_a), .ld_second_o(ld_b), .cmp_res_i(cmp),
        .mix_o(mix), .fail_o(fail), .done_o(done), .busy_o(busy)
    );

    // Behavioural comparator cells
    always_ff @(posedge clk) begin
        for (int i = 0; i < NC; i++) begin
            if (ld_a) sa[i] <= tdat;
            if (ld_b) sb[i] <= tdat;
        end
    end

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            cmp[i] = (sa[i] < sb[i]) ^ (inject && (i == 2));
        end
    end

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One accepted handshake; called and returns at a negedge
    task automatic hs(input bit second);
        req = 1'b1;
        @(negedge clk);
        model = nxt(model);
        chk(ack == 1'b1, "R3 ack rise", int'(ack), 1);
        chk(tdat == model[7:0], "R2 tdat after step", int'(tdat), int'(model[7:0]));
        chk(ld_a == !second, "R4 ld_first", int'(ld_a), int'(!second));
        chk(ld_b == second, "R4 ld_second", int'(ld_b), int'(second));
        req = 1'b0;
        @(negedge clk);
        chk(ack == 1'b0, "R3 ack fall", int'(ack), 0);
        chk((ld_a | ld_b) == 1'b0, "R4 strobe width", int'({ld_a, ld_b}), 0);
    endtask

    task automatic pair(input bit exp_fail);
        hs(1'b0);
        hs(1'b1);
        @(negedge clk);
        chk(mix == inject, "R5 parity", int'(mix), int'(inject));
        chk(fail == exp_fail, "R6 fail flag", int'(fail), int'(exp_fail));
    endtask

    // Request that must be ignored
    task automatic hs_ignored(input string tag);
        logic [7:0] held;
        held = tdat;
        req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(ack == 1'b0, tag, int'(ack), 0);
            chk(tdat == held, tag, int'(tdat), int'(held));
        end
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        model = SEEDV;
        chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        chk(done == 1'b0, "R8 done cleared", int'(done), 0);
        chk(fail == 1'b0, "R8 fail cleared", int'(fail), 0);
        chk(tdat == SEEDV[7:0], "R8 reseed", int'(tdat), int'(SEEDV[7:0]));
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            sa[i] = '0;
            sb[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ack == 0 && ld_a == 0 && ld_b == 0, "R1 handshake idle", int'({ack, ld_a, ld_b}), 0);
        chk(fail == 0 && done == 0 && busy == 0, "R1 flags", int'({fail, done, busy}), 0);
        chk(tdat == SEEDV[7:0], "R1 seed byte", int'(tdat), int'(SEEDV[7:0]));

        // R9 no stepping before start
        hs_ignored("R9 idle request");

        // Fault-free run
        kick();
        for (int p = 0; p < NP; p++) begin
            pair(1'b0);
            chk(done == (p == NP - 1), "R7 done timing", int'(done), int'(p == NP - 1));
            chk(busy == (p != NP - 1), "R7 busy timing", int'(busy), int'(p != NP - 1));
        end
        hs_ignored("R7 request after done");

        // R10 parity high while idle is ignored
        inject = 1'b1;
        repeat (3) @(negedge clk);
        chk(mix == 1'b1, "R5 parity with fault", int'(mix), 1);
        chk(fail == 1'b0, "R10 idle parity ignored", int'(fail), 0);

        // Faulty first pair then clean pairs: fail is sticky
        kick();
        pair(1'b1);
        inject = 1'b0;
        for (int p = 1; p < NP; p++) begin
            pair(1'b1);
        end
        chk(done == 1'b1, "R7 done second run", int'(done), 1);

        // Restart clears the flag; fault only on the last pair
        kick();
        for (int p = 0; p < NP - 1; p++) pair(1'b0);
        inject = 1'b1;
        pair(1'b1);
        chk(done == 1'b1, "R7 done third run", int'(done), 1);
        inject = 1'b0;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule